// File: doc/BRIEF.md
# Ripple Add/Subtract Unit with Compare Predicates

This block adds or subtracts two W-bit two's-complement operands in a single combinational pass. A subtract control picks the operation. When it is high, every bit of the second operand is inverted and the control itself supplies the carry into bit 0, so the datapath computes A + ~B + 1. The sum is formed by a chain of one-bit full-adder cells. The carry ripples from the least significant cell to the most significant cell, so the slowest path through the block runs the length of that chain.

Alongside the result, the block reports four condition flags: zero, negative, carry-out and signed overflow. A 4-bit predicate code selects one comparison outcome, which is derived only from those flags. Signed predicates read the negative, overflow and zero flags. Unsigned predicates read the carry, which after a subtraction means that no borrow occurred. The comparison is meaningful when subtract is asserted.

The operand stream uses valid/ready, with no storage in the block. The output side mirrors the input side in the same cycle: the result is valid exactly when the input is valid, and the input is ready exactly when the consumer is ready. A transfer therefore happens on any edge where in_valid and out_ready are both high. A producer held off by back-pressure must keep its operands stable, because the outputs always follow the present inputs.

Top module: `addsub_cmp_unit`

## Requirements
- R1: With sub_en low, result equals (op_a + op_b) mod 2^W and flag_c equals bit W of the unbounded unsigned sum.
- R2: With sub_en high, result equals (op_a - op_b) mod 2^W and flag_c is 1 exactly when op_a >= op_b as unsigned values.
- R3: flag_v is 1 exactly when the signed sum (sub_en low) or signed difference (sub_en high) lies outside -2^(W-1) .. 2^(W-1)-1.
- R4: flag_z is 1 exactly when every result bit is 0, and flag_n equals result bit W-1.
- R5: With sub_en high, pred_sel codes 0 (equal), 1 (not equal), 2 (signed less), 3 (signed less-or-equal), 4 (signed greater) and 5 (signed greater-or-equal) make cmp_out the truth of that relation between op_a and op_b.
- R6: With sub_en high, pred_sel codes 6 (unsigned less), 7 (unsigned less-or-equal), 8 (unsigned greater) and 9 (unsigned greater-or-equal) make cmp_out the truth of that relation.
- R7: pred_sel codes 10 to 15 drive cmp_out to 0 whatever the operands and sub_en.
- R8: out_valid equals in_valid and in_ready equals out_ready in the same cycle, and all data outputs depend only on the present inputs.
- R9: The longest carry path gives the right answer: all-ones plus one yields result 0 with flag_c and flag_z set, and 0 minus 1 yields all-ones with flag_c clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Block can accept operands (follows out_ready) |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sub_en | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| pred_sel | input | 4 | Comparison predicate code |
| out_valid | output | 1 | Result is valid (follows in_valid) |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | W | Sum or difference |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result MSB |
| flag_c | output | 1 | Carry out of the top cell |
| flag_v | output | 1 | Signed overflow |
| cmp_out | output | 1 | Selected predicate outcome |

## Verification
The bench targets the most negative value, zero, all-ones and equal operands, along with a long run of random vectors. Subtracting the most negative value exposes an overflow term that reads the raw op_b sign instead of the inverted one, which would report no overflow. All-ones plus one exercises the full carry chain: a broken link in the chain leaves stray ones in the result and drops the carry. Equal operands separate the "or equal" predicates from the strict ones. Mixed-sign pairs separate signed from unsigned ordering, which a design that swapped N^V for the carry would report backwards.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [3:0] {
    PR_EQ  = 4'd0,
    PR_NE  = 4'd1,
    PR_LT  = 4'd2,
    PR_LE  = 4'd3,
    PR_GT  = 4'd4,
    PR_GE  = 4'd5,
    PR_LTU = 4'd6,
    PR_LEU = 4'd7,
    PR_GTU = 4'd8,
    PR_GEU = 4'd9
  } pred_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = x ^ y;
  assign s    = half ^ ci;
  assign co   = (x & y) | (half & ci);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  localparam int NC = W + 1;
  logic [NC-1:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    fa_cell u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (carry[i]),
      .s  (s[i]),
      .co (carry[i+1])
    );
  end

  assign cout = carry[NC-1];
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         cout,
  input  logic         a_msb,
  input  logic         b_eff_msb,
  output flags_t       flags
);
  localparam int MSB = W - 1;

  always_comb begin
    flags.z = ~|res;
    flags.n = res[MSB];
    flags.c = cout;
    flags.v = (a_msb == b_eff_msb) && (res[MSB] != a_msb);
  end
endmodule

// File: rtl/pred_sel.sv
module pred_sel
  import addsub_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] code,
  output logic       hit
);
  logic lt_s;

  always_comb begin
    lt_s = flags.n ^ flags.v;
    case (code)
      PR_EQ:   hit = flags.z;
      PR_NE:   hit = ~flags.z;
      PR_LT:   hit = lt_s;
      PR_LE:   hit = flags.z | lt_s;
      PR_GT:   hit = ~(flags.z | lt_s);
      PR_GE:   hit = ~lt_s;
      PR_LTU:  hit = ~flags.c;
      PR_LEU:  hit = ~flags.c | flags.z;
      PR_GTU:  hit = flags.c & ~flags.z;
      PR_GEU:  hit = flags.c;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_cmp_unit.sv
module addsub_cmp_unit
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_en,
  input  logic [3:0]   pred_sel,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_c,
  output logic         flag_v,
  output logic         cmp_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         cout;
  flags_t       fl;

  assign b_eff = op_b ^ {W{sub_en}};

  ripple_chain #(.W(W)) u_chain (
    .x    (op_a),
    .y    (b_eff),
    .cin  (sub_en),
    .s    (sum),
    .cout (cout)
  );

  flag_gen #(.W(W)) u_flags (
    .res       (sum),
    .cout      (cout),
    .a_msb     (op_a[MSB]),
    .b_eff_msb (b_eff[MSB]),
    .flags     (fl)
  );

  pred_sel u_pred (
    .flags (fl),
    .code  (pred_sel),
    .hit   (cmp_out)
  );

  assign result    = sum;
  assign flag_z    = fl.z;
  assign flag_n    = fl.n;
  assign flag_c    = fl.c;
  assign flag_v    = fl.v;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/addsub_cmp_chk.sv
module addsub_cmp_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sub_en,
  input logic [3:0]   pred_sel,
  input logic [W-1:0] result,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v,
  input logic         cmp_out
);
  localparam int WX = W + 1;
  logic [WX-1:0] ext_sum;
  logic signed [WX-1:0] s_wide;
  logic          known;

  always_comb begin
    known   = !$isunknown({op_a, op_b, sub_en, pred_sel});
    ext_sum = {1'b0, op_a} + {1'b0, op_b};
    s_wide  = sub_en ? ($signed({op_a[W-1], op_a}) - $signed({op_b[W-1], op_b}))
                     : ($signed({op_a[W-1], op_a}) + $signed({op_b[W-1], op_b}));
    if (known) begin
      // R1
      p_add_sum_r1: assert (sub_en || ({flag_c, result} == ext_sum));
      // R2
      p_sub_diff_r2: assert (!sub_en || (result == op_a - op_b && flag_c == (op_a >= op_b)));
      // R3
      p_no_overflow_r3: assert (flag_v == (s_wide[W] != s_wide[W-1]));
      // R4
      p_zero_eq_r4: assert (!sub_en || (flag_z == (op_a == op_b)));
      // R5
      p_signed_lt_r5: assert (!(sub_en && pred_sel == 4'd2) || (cmp_out == ($signed(op_a) < $signed(op_b))));
      // R6
      p_unsigned_lt_r6: assert (!(sub_en && pred_sel == 4'd6) || (cmp_out == (op_a < op_b)));
      // R7
      p_unused_code_r7: assert (pred_sel < 4'd10 || !cmp_out);
    end
  end
endmodule

bind addsub_cmp_unit addsub_cmp_chk #(.W(W)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .sub_en   (sub_en),
  .pred_sel (pred_sel),
  .result   (result),
  .flag_z   (flag_z),
  .flag_c   (flag_c),
  .flag_v   (flag_v),
  .cmp_out  (cmp_out)
);

// File: tb/tb_addsub_cmp_unit.sv
module tb_addsub_cmp_unit;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0] op_a, op_b, result;
  logic         sub_en;
  logic [3:0]   pred_sel;
  logic         flag_z, flag_n, flag_c, flag_v, cmp_out;

  addsub_cmp_unit #(.W(W)) dut (
    .in_valid(in_valid), .in_ready(in_ready), .op_a(op_a), .op_b(op_b),
    .sub_en(sub_en), .pred_sel(pred_sel), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .flag_z(flag_z), .flag_n(flag_n),
    .flag_c(flag_c), .flag_v(flag_v), .cmp_out(cmp_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         s;
    logic [3:0]   p;
    logic         iv;
    logic         ordy;
  } vec_t;
  vec_t pending[$];

  task automatic flag_fail(string req, string what, longint act, longint exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // behavioural reference, evaluated on the vector currently applied
  task automatic check_now(vec_t v);
    longint ua, ub, sa, sb, wide, ures, top;
    longint exp_res;
    logic   exp_c, exp_v, exp_z, exp_n, exp_cmp, check_cmp;
    top = longint'(1) << W;
    ua = longint'(v.a);
    ub = longint'(v.b);
    sa = longint'($signed(v.a));
    sb = longint'($signed(v.b));
    if (v.s) begin
      ures = ua - ub;
      exp_c = (ua >= ub);          // R2
      wide = sa - sb;
    end else begin
      ures = ua + ub;
      exp_c = (ures >= top);       // R1
      wide = sa + sb;
    end
    exp_res = ((ures % top) + top) % top;
    exp_v = (wide > (top/2 - 1)) || (wide < -(top/2));   // R3
    exp_z = (exp_res == 0);                              // R4
    exp_n = exp_res[W-1];
    check_cmp = 1'b1;
    case (v.p)
      4'd0: exp_cmp = (ua == ub);
      4'd1: exp_cmp = (ua != ub);
      4'd2: exp_cmp = (sa <  sb);
      4'd3: exp_cmp = (sa <= sb);
      4'd4: exp_cmp = (sa >  sb);
      4'd5: exp_cmp = (sa >= sb);
      4'd6: exp_cmp = (ua <  ub);
      4'd7: exp_cmp = (ua <= ub);
      4'd8: exp_cmp = (ua >  ub);
      4'd9: exp_cmp = (ua >= ub);
      default: exp_cmp = 1'b0;
    endcase
    if (v.p < 4'd10 && !v.s) check_cmp = 1'b0;
    n_cmp++;
    if (longint'(result) != exp_res) flag_fail(v.s ? "R2" : "R1", "result", longint'(result), exp_res);
    if (flag_c != exp_c) flag_fail(v.s ? "R2" : "R1", "flag_c", longint'(flag_c), longint'(exp_c));
    if (flag_v != exp_v) flag_fail("R3", "flag_v", longint'(flag_v), longint'(exp_v));
    if (flag_z != exp_z) flag_fail("R4", "flag_z", longint'(flag_z), longint'(exp_z));
    if (flag_n != exp_n) flag_fail("R4", "flag_n", longint'(flag_n), longint'(exp_n));
    if (check_cmp && cmp_out != exp_cmp)
      flag_fail(v.p >= 4'd10 ? "R7" : (v.p >= 4'd6 ? "R6" : "R5"), "cmp_out",
                longint'(cmp_out), longint'(exp_cmp));
    if (out_valid != v.iv) flag_fail("R8", "out_valid", longint'(out_valid), longint'(v.iv));
    if (in_ready != v.ordy) flag_fail("R8", "in_ready", longint'(in_ready), longint'(v.ordy));
  endtask

  function automatic vec_t mk(logic [W-1:0] a, logic [W-1:0] b, logic s, logic [3:0] p);
    vec_t v;
    v.a = a; v.b = b; v.s = s; v.p = p;
    v.iv = 1'b1; v.ordy = 1'b1;
    return v;
  endfunction

  task automatic apply(vec_t v);
    @(posedge clk);
    #1;
    op_a = v.a; op_b = v.b; sub_en = v.s; pred_sel = v.p;
    in_valid = v.iv; out_ready = v.ordy;
    pending.push_back(v);
    @(negedge clk);
    check_now(pending.pop_front());
  endtask

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    in_valid = 0; out_ready = 0; op_a = '0; op_b = '0; sub_en = 0; pred_sel = 4'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state: handshake mirrors, zero operands add to zero (R8, R4)
    v = mk('0, '0, 1'b0, 4'd12); v.iv = 1'b0; v.ordy = 1'b0;
    apply(v);
    // R9 long carry path
    apply(mk(ONES, 32'd1, 1'b0, 4'd0));
    apply(mk('0, 32'd1, 1'b1, 4'd6));
    // R3 overflow corners with most negative value
    apply(mk('0, MINV, 1'b1, 4'd2));
    apply(mk(MINV, 32'd1, 1'b1, 4'd4));
    apply(mk(MAXV, 32'd1, 1'b0, 4'd0));
    apply(mk(MINV, MINV, 1'b0, 4'd0));
    // R5 R6 equal operands across every predicate
    for (int p = 0; p < 16; p++) apply(mk(32'h1234_5678, 32'h1234_5678, 1'b1, 4'(p)));
    // R5 R6 mixed sign ordering across every predicate
    for (int p = 0; p < 16; p++) apply(mk(ONES, 32'd1, 1'b1, 4'(p)));
    for (int p = 0; p < 16; p++) apply(mk(32'd1, ONES, 1'b1, 4'(p)));
    for (int p = 0; p < 16; p++) apply(mk(MINV, MAXV, 1'b1, 4'(p)));
    // R7 unused codes with adds too
    for (int p = 10; p < 16; p++) apply(mk(32'd5, 32'd3, 1'b0, 4'(p)));
    // R8 back-pressure combinations
    for (int k = 0; k < 4; k++) begin
      v = mk(32'd7, 32'd9, 1'b1, 4'd2);
      v.iv = k[0]; v.ordy = k[1];
      apply(v);
    end
    // random sweep (R1..R8)
    for (int i = 0; i < 2000; i++) begin
      v = mk($urandom, $urandom, 1'($urandom), 4'($urandom));
      if (i % 7 == 0) v.b = v.a;
      if (i % 11 == 0) v.a = MINV;
      if (i % 13 == 0) v.b = ONES;
      v.iv = 1'($urandom); v.ordy = 1'($urandom);
      apply(v);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule